// File: doc/BRIEF.md
# Parallel Panel Command Bus Controller

This block lets a host send command (index) words and parameter (data) words to a smart display panel over an asynchronous parallel bus, and fetch words back. It is reached through a small register port. Software stages a word, then writes a trigger. The block then runs one bus cycle on one of its panel channels. It drives a chip select for the chosen channel, a register-select line, a write or read strobe and a data bus whose drive is split into an output, an output enable and an input.

Each transfer has three phases: setup, strobe and hold. The length of each phase is programmable in clocks. The bus width of each channel comes from a 4-bit mode code. Outgoing payloads and captured read words are masked to that width. Only one transfer is in flight at a time. A status busy flag covers the whole transfer, and a trigger that cannot be honoured raises a sticky error flag.

The register port has plain write-enable and read-address pins, with no handshake. Writes land on the next rising clock. Reads return the addressed register combinationally.

Top module: `panel_cmd_bus`

## Requirements
- R1: After reset every chip select, `pnl_wr_n` and `pnl_rd_n` are high, `pnl_db_oe` is low, and every register reads zero. The register addresses are: 0 staged word, 1 read register, 2 write trigger, 3 read trigger, 4 status, 5 timing, 6 mode.
- R2: Writing address 2 with bit 0 set starts one write cycle. The cycle has setup, then `pnl_wr_n` low, then hold. The phases last timing bits [3:0], [7:4] and [11:8] clocks respectively, and a field value of 0 counts as 1. `pnl_wr_n` and `pnl_rd_n` are never low together.
- R3: During a write, `pnl_rs` follows bit 24 of the staged word: low for an index cycle and high for a data cycle. It is high during a read, and it stays stable while the chip select is low.
- R4: Trigger bit 1 selects channel 1 instead of channel 0. Only the chip select of the selected channel goes low, and never more than one chip select is low at a time.
- R5: The chip select is low for at least one clock before the strobe falls and for at least one clock after it rises.
- R6: Status bit 1 (busy) reads 1 from the clock after an accepted trigger. It clears when the hold phase ends, so it stays set for setup+strobe+hold clocks.
- R7: A trigger written while busy is ignored and sets status bit 2. Status bit 2 stays set until status is written with bit 2 set.
- R8: A write trigger is rejected, setting status bit 2, when bit 28 of the staged word is clear. A read trigger is rejected in the same way unless it was prepared by writing address 1 with bit 24 set.
- R9: The mode register holds channel n's code in bits [4n+3:4n]. The codes map to bus widths as follows: 0 to 3 give 8 bits, 4 gives 9, 5 gives 12, 7 to 9 give 16, 10 gives 18 and 11 gives 24. The low payload bits are driven masked to that width. Codes 6 and 12 to 15 make a trigger be rejected with status bit 2.
- R10: A read keeps `pnl_db_oe` low and pulses `pnl_rd_n`. It samples `pnl_db_in` on the last clock of the strobe, masked to the channel width. The low 16 bits of that sample appear in bits [15:0] of address 1. Bit 24 of address 1 reads as the prepared flag, and that flag clears when the sample is taken.
- R11: The payload, register select, channel, width and timing are captured when a trigger is accepted. Register writes made during the transfer do not alter it.
- R12: A trigger write with bit 0 clear starts nothing and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_waddr | input | 3 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | 32 | Register read data (combinational) |
| pnl_cs_n | output | NUM_CH | Per-channel chip select, active low |
| pnl_rs | output | 1 | Register select: 0 index, 1 data |
| pnl_wr_n | output | 1 | Write strobe, active low |
| pnl_rd_n | output | 1 | Read strobe, active low |
| pnl_db_out | output | DATA_W | Data bus drive value |
| pnl_db_oe | output | 1 | Data bus output enable |
| pnl_db_in | input | DATA_W | Data bus sampled value |

## Verification
The properties take for granted that the register port changes only between clock edges and that software polls busy before triggering. The stimulus respects the first point throughout. It breaks the second point on purpose, to show that such a trigger is rejected without disturbing the strobes. The properties also take for granted that `pnl_db_in` is meaningful only in the last strobe clock of a read. The stimulus lets it change on every clock, so that a sample taken in the wrong clock gives a visibly different word.

// File: rtl/panel_bus_pkg.sv
package panel_bus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] A_STAGE  = 3'd0;
  localparam logic [REG_AW-1:0] A_RDREG  = 3'd1;
  localparam logic [REG_AW-1:0] A_WTRIG  = 3'd2;
  localparam logic [REG_AW-1:0] A_RTRIG  = 3'd3;
  localparam logic [REG_AW-1:0] A_STATUS = 3'd4;
  localparam logic [REG_AW-1:0] A_TIMING = 3'd5;
  localparam logic [REG_AW-1:0] A_MODE   = 3'd6;

  localparam int BIT_WFLAG = 28;
  localparam int BIT_KIND  = 24;
  localparam int BIT_GO    = 0;
  localparam int BIT_BUSY  = 1;
  localparam int BIT_ERR   = 2;
  localparam int MODE_W    = 4;
  localparam int RD_W      = 16;

  // bus width for a mode code; 0 marks an unusable code
  function automatic int bus_width(input logic [MODE_W-1:0] code);
    case (code)
      4'd0, 4'd1, 4'd2, 4'd3: return 8;
      4'd4:                   return 9;
      4'd5:                   return 12;
      4'd7, 4'd8, 4'd9:       return 16;
      4'd10:                  return 18;
      4'd11:                  return 24;
      default:                return 0;
    endcase
  endfunction

endpackage

// File: rtl/mode_decode.sv
module mode_decode
  import panel_bus_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic [MODE_W-1:0] code,
  output logic              ok,
  output logic [DATA_W-1:0] mask
);

  int w;

  always_comb begin
    w    = bus_width(code);
    ok   = (w != 0) && (w <= DATA_W);
    mask = '0;
    for (int b = 0; b < DATA_W; b++) begin
      if (b < w) mask[b] = 1'b1;
    end
  end

endmodule

// File: rtl/strobe_seq.sv
module strobe_seq
  import panel_bus_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 4,
  parameter int CH_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_rd,
  input  logic              start_rs,
  input  logic [CH_W-1:0]   start_ch,
  input  logic [DATA_W-1:0] start_data,
  input  logic [DATA_W-1:0] start_mask,
  input  logic [CNT_W-1:0]  t_setup,
  input  logic [CNT_W-1:0]  t_strobe,
  input  logic [CNT_W-1:0]  t_hold,
  input  logic [DATA_W-1:0] db_in,
  output logic              busy,
  output logic [CH_W-1:0]   ch_q,
  output logic              rs,
  output logic              wr_n,
  output logic              rd_n,
  output logic [DATA_W-1:0] db_out,
  output logic              db_oe,
  output logic              cap_valid,
  output logic [RD_W-1:0]   cap_word
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_e            ph;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  strobe_q;
  logic [CNT_W-1:0]  hold_q;
  logic              rd_q;
  logic              rs_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] mask_q;

  function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      cnt      <= '0;
      strobe_q <= '0;
      hold_q   <= '0;
      rd_q     <= 1'b0;
      rs_q     <= 1'b0;
      ch_q     <= '0;
      data_q   <= '0;
      mask_q   <= '0;
    end else begin
      case (ph)
        PH_IDLE: begin
          if (start) begin
            ph       <= PH_SETUP;
            cnt      <= at_least_one(t_setup);
            strobe_q <= at_least_one(t_strobe);
            hold_q   <= at_least_one(t_hold);
            rd_q     <= start_rd;
            rs_q     <= start_rs;
            ch_q     <= start_ch;
            data_q   <= start_data & start_mask;
            mask_q   <= start_mask;
          end
        end
        PH_SETUP: begin
          if (cnt == ONE) begin
            ph  <= PH_STROBE;
            cnt <= strobe_q;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        PH_STROBE: begin
          if (cnt == ONE) begin
            ph  <= PH_HOLD;
            cnt <= hold_q;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        default: begin
          if (cnt == ONE) begin
            ph  <= PH_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt - ONE;
          end
        end
      endcase
    end
  end

  always_comb begin
    busy      = (ph != PH_IDLE);
    wr_n      = !((ph == PH_STROBE) && !rd_q);
    rd_n      = !((ph == PH_STROBE) && rd_q);
    db_oe     = busy && !rd_q;
    db_out    = db_oe ? data_q : '0;
    rs        = busy ? rs_q : 1'b0;
    cap_valid = (ph == PH_STROBE) && (cnt == ONE) && rd_q;
    cap_word  = RD_W'(db_in & mask_q);
  end

endmodule

// File: rtl/panel_regs.sv
module panel_regs
  import panel_bus_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1,
  parameter int CNT_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [REG_AW-1:0]        reg_waddr,
  input  logic [31:0]              reg_wdata,
  input  logic [REG_AW-1:0]        reg_raddr,
  output logic [31:0]              reg_rdata,
  input  logic                     busy,
  input  logic [NUM_CH-1:0]        mode_ok,
  input  logic                     cap_valid,
  input  logic [RD_W-1:0]          cap_word,
  output logic [31:0]              stage_q,
  output logic [3*CNT_W-1:0]       timing_q,
  output logic [NUM_CH*MODE_W-1:0] mode_q,
  output logic                     start,
  output logic                     start_rd,
  output logic [CH_W-1:0]          start_ch
);

  logic            prep_q;
  logic            err_q;
  logic [RD_W-1:0] rd_word_q;
  logic            wr_go, rd_go, ch_ok, wr_take, rd_take, reject;

  always_comb begin
    wr_go    = reg_we && (reg_waddr == A_WTRIG) && reg_wdata[BIT_GO];
    rd_go    = reg_we && (reg_waddr == A_RTRIG) && reg_wdata[BIT_GO];
    start_ch = reg_wdata[CH_W:1];
    ch_ok    = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (start_ch == CH_W'(i)) ch_ok = mode_ok[i];
    end
    wr_take  = wr_go && !busy && stage_q[BIT_WFLAG] && ch_ok;
    rd_take  = rd_go && !busy && prep_q && ch_ok;
    reject   = (wr_go || rd_go) && !(wr_take || rd_take);
    start    = wr_take || rd_take;
    start_rd = rd_take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q   <= '0;
      timing_q  <= '0;
      mode_q    <= '0;
      prep_q    <= 1'b0;
      err_q     <= 1'b0;
      rd_word_q <= '0;
    end else begin
      if (cap_valid) begin
        rd_word_q <= cap_word;
        prep_q    <= 1'b0;
      end
      if (reg_we) begin
        case (reg_waddr)
          A_STAGE:  stage_q  <= reg_wdata;
          A_RDREG:  prep_q   <= reg_wdata[BIT_KIND];
          A_TIMING: timing_q <= reg_wdata[3*CNT_W-1:0];
          A_MODE:   mode_q   <= reg_wdata[NUM_CH*MODE_W-1:0];
          A_STATUS: if (reg_wdata[BIT_ERR]) err_q <= 1'b0;
          default: ;
        endcase
      end
      if (reject) err_q <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_raddr)
      A_STAGE: reg_rdata = stage_q;
      A_RDREG: begin
        reg_rdata[RD_W-1:0]  = rd_word_q;
        reg_rdata[BIT_KIND]  = prep_q;
      end
      A_STATUS: begin
        reg_rdata[BIT_BUSY] = busy;
        reg_rdata[BIT_ERR]  = err_q;
      end
      A_TIMING: reg_rdata = 32'(timing_q);
      A_MODE:   reg_rdata = 32'(mode_q);
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/panel_cmd_bus.sv
module panel_cmd_bus
  import panel_bus_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 24,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_waddr,
  input  logic [31:0]       reg_wdata,
  input  logic [2:0]        reg_raddr,
  output logic [31:0]       reg_rdata,
  output logic [NUM_CH-1:0] pnl_cs_n,
  output logic              pnl_rs,
  output logic              pnl_wr_n,
  output logic              pnl_rd_n,
  output logic [DATA_W-1:0] pnl_db_out,
  output logic              pnl_db_oe,
  input  logic [DATA_W-1:0] pnl_db_in
);

  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [31:0]              stage_q;
  logic [3*CNT_W-1:0]       timing_q;
  logic [NUM_CH*MODE_W-1:0] mode_q;
  logic [NUM_CH-1:0]        mode_ok;
  logic [DATA_W-1:0]        mask_arr [NUM_CH];
  logic [DATA_W-1:0]        sel_mask;
  logic                     start, start_rd;
  logic [CH_W-1:0]          start_ch;
  logic                     seq_busy;
  logic [CH_W-1:0]          seq_ch;
  logic                     cap_valid;
  logic [RD_W-1:0]          cap_word;

  panel_regs #(.NUM_CH(NUM_CH), .CH_W(CH_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .busy(seq_busy), .mode_ok(mode_ok),
    .cap_valid(cap_valid), .cap_word(cap_word),
    .stage_q(stage_q), .timing_q(timing_q), .mode_q(mode_q),
    .start(start), .start_rd(start_rd), .start_ch(start_ch)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    mode_decode #(.DATA_W(DATA_W)) u_dec (
      .code(mode_q[i*MODE_W +: MODE_W]),
      .ok(mode_ok[i]),
      .mask(mask_arr[i])
    );
    assign pnl_cs_n[i] = !(seq_busy && (seq_ch == CH_W'(i)));
  end

  always_comb begin
    sel_mask = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (start_ch == CH_W'(i)) sel_mask = mask_arr[i];
    end
  end

  strobe_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W), .CH_W(CH_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_rd(start_rd),
    .start_rs(start_rd ? 1'b1 : stage_q[BIT_KIND]),
    .start_ch(start_ch),
    .start_data(stage_q[DATA_W-1:0]),
    .start_mask(sel_mask),
    .t_setup(timing_q[CNT_W-1:0]),
    .t_strobe(timing_q[2*CNT_W-1:CNT_W]),
    .t_hold(timing_q[3*CNT_W-1:2*CNT_W]),
    .db_in(pnl_db_in),
    .busy(seq_busy), .ch_q(seq_ch),
    .rs(pnl_rs), .wr_n(pnl_wr_n), .rd_n(pnl_rd_n),
    .db_out(pnl_db_out), .db_oe(pnl_db_oe),
    .cap_valid(cap_valid), .cap_word(cap_word)
  );

endmodule

// File: rtl/panel_cmd_bus_chk.sv
module panel_cmd_bus_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] cs_n,
  input logic              rs,
  input logic              wr_n,
  input logic              rd_n,
  input logic              db_oe,
  input logic              busy
);

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_n && !rd_n));

  // R4
  single_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R5
  strobe_in_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n || !rd_n) |-> !(&cs_n));

  // R5
  select_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!wr_n && $past(wr_n)) || (!rd_n && $past(rd_n))) |-> !(&$past(cs_n)));

  // R5
  select_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_n && !$past(wr_n)) || (rd_n && !$past(rd_n))) |-> !(&cs_n));

  // R3
  rs_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&cs_n) && !(&$past(cs_n))) |-> $stable(rs));

  // R10
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(db_oe && !rd_n));

  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(wr_n) && $past(rd_n)));

endmodule

bind panel_cmd_bus panel_cmd_bus_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(pnl_cs_n), .rs(pnl_rs),
  .wr_n(pnl_wr_n), .rd_n(pnl_rd_n), .db_oe(pnl_db_oe), .busy(seq_busy)
);

// File: tb/panel_cmd_bus_bench.sv
module panel_cmd_bus_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [2:0]  reg_raddr = 3'd4;
  logic [31:0] reg_rdata;
  logic [1:0]  pnl_cs_n;
  logic        pnl_rs, pnl_wr_n, pnl_rd_n, pnl_db_oe;
  logic [23:0] pnl_db_out;
  logic [23:0] pnl_db_in = 24'h0A0B0C;
  logic        freeze = 1'b0;

  int n_vec = 0;
  int n_bad = 0;
  bit started = 0;

  always #10 clk = ~clk;

  panel_cmd_bus u_panel_cmd_bus (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .pnl_cs_n(pnl_cs_n), .pnl_rs(pnl_rs), .pnl_wr_n(pnl_wr_n),
    .pnl_rd_n(pnl_rd_n), .pnl_db_out(pnl_db_out), .pnl_db_oe(pnl_db_oe),
    .pnl_db_in(pnl_db_in)
  );

  // behavioural reference model
  logic [31:0] m_stage, m_timing, m_mode;
  logic        m_prep, m_err, t_rd, t_rs;
  logic [15:0] m_rdval;
  logic [23:0] t_data, t_mask;
  int ph, left, t_w, t_h, t_ch;

  function automatic int width_of(input int code);
    if (code <= 3) return 8;
    if (code == 4) return 9;
    if (code == 5) return 12;
    if (code >= 7 && code <= 9) return 16;
    if (code == 10) return 18;
    if (code == 11) return 24;
    return 0;
  endfunction

  function automatic int atl1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic model_reset();
    m_stage = 0; m_timing = 0; m_mode = 0; m_prep = 0; m_err = 0; m_rdval = 0;
    ph = 0; left = 0; t_w = 1; t_h = 1; t_ch = 0; t_rd = 0; t_rs = 0;
    t_data = 0; t_mask = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
      started = 1;
    end else begin
      bit was_busy;
      was_busy = (ph != 0);
      if (ph == 1) begin
        if (left == 1) begin ph = 2; left = t_w; end else left--;
      end else if (ph == 2) begin
        if (left == 1) begin
          if (t_rd) begin m_rdval = 16'(pnl_db_in & t_mask); m_prep = 0; end
          ph = 3; left = t_h;
        end else left--;
      end else if (ph == 3) begin
        if (left == 1) ph = 0; else left--;
      end
      if (reg_we) begin
        case (reg_waddr)
          3'd0: m_stage = reg_wdata;
          3'd1: m_prep = reg_wdata[24];
          3'd4: if (reg_wdata[2]) m_err = 0;
          3'd5: m_timing = reg_wdata & 32'hFFF;
          3'd6: m_mode = reg_wdata & 32'hFF;
          3'd2, 3'd3: if (reg_wdata[0]) begin
            int ch, w;
            bit ok, rd;
            rd = (reg_waddr == 3'd3);
            ch = int'(reg_wdata[1]);
            w  = width_of(int'((m_mode >> (4 * ch)) & 32'hF));
            ok = !was_busy && (w != 0) && (rd ? m_prep : m_stage[28]);
            if (ok) begin
              ph = 1; left = atl1(int'(m_timing[3:0]));
              t_w = atl1(int'(m_timing[7:4])); t_h = atl1(int'(m_timing[11:8]));
              t_rd = rd; t_rs = rd ? 1'b1 : m_stage[24]; t_ch = ch;
              t_mask = 24'((64'd1 << w) - 1);
              t_data = m_stage[23:0] & t_mask;
            end else m_err = 1;
          end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_stage;
      3'd1: return {7'd0, m_prep, 8'd0, m_rdval};
      3'd4: return {29'd0, m_err, (ph != 0), 1'b0};
      3'd5: return m_timing;
      3'd6: return m_mode;
      default: return 32'd0;
    endcase
  endfunction

  task automatic cmp(input string tag, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h at %0t", tag, what, got, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (started) begin
      logic [1:0] e_cs;
      bit act;
      act  = (ph != 0);
      e_cs = act ? ~(2'b01 << t_ch) : 2'b11;
      cmp("R4", "cs_n", 32'(pnl_cs_n), 32'(e_cs));
      cmp("R3", "rs", 32'(pnl_rs), 32'(act ? t_rs : 1'b0));
      cmp("R2", "wr_n", 32'(pnl_wr_n), 32'(!(ph == 2 && !t_rd)));
      cmp("R10", "rd_n", 32'(pnl_rd_n), 32'(!(ph == 2 && t_rd)));
      cmp("R10", "db_oe", 32'(pnl_db_oe), 32'(act && !t_rd));
      cmp("R9", "db_out", 32'(pnl_db_out), 32'((act && !t_rd) ? t_data : 24'd0));
      cmp("R1", "reg_rdata", reg_rdata, m_read(reg_raddr));
    end
  end

  // panel data bus changes every clock unless frozen
  always @(posedge clk) begin
    #2;
    if (!freeze) pnl_db_in = pnl_db_in + 24'h13579B;
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    tick();
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic wait_idle();
    while (ph != 0) tick();
    tick();
  endtask

  initial begin
    repeat (5) tick();
    rst_n = 1'b1;
    tick();
    @(negedge clk);
    // R1 reset state
    cmp("R1", "cs_n idle", 32'(pnl_cs_n), 32'h3);
    cmp("R1", "strobes idle", 32'({pnl_wr_n, pnl_rd_n, pnl_db_oe}), 32'h6);
    cmp("R1", "status", reg_rdata, 32'h0);

    // R2 R3: index write on channel 0, default timing (all ones), 8-bit mode
    wreg(3'd0, 32'h1000_00A5);
    wreg(3'd2, 32'h1);
    @(negedge clk);
    cmp("R3", "index rs", 32'(pnl_rs), 32'h0);
    cmp("R4", "ch0 select", 32'(pnl_cs_n), 32'h2);
    wait_idle();

    // R4 R5 R6: data write on channel 1, 24-bit, setup 2 strobe 3 hold 4
    wreg(3'd6, 32'hB0);
    wreg(3'd5, 32'h432);
    wreg(3'd0, 32'h1112_3456);
    wreg(3'd2, 32'h3);
    begin
      int n;
      n = 0;
      forever begin
        @(negedge clk);
        if (n == 0) cmp("R4", "ch1 select", 32'(pnl_cs_n), 32'h1);
        if (!reg_rdata[1]) break;
        n++;
      end
      cmp("R6", "busy length", 32'(n), 32'd9);
    end
    tick();

    // R7 R11: trigger while busy, register writes during a transfer
    wreg(3'd5, 32'h555);
    wreg(3'd2, 32'h1);
    wreg(3'd2, 32'h3);
    wreg(3'd0, 32'h1100_0077);
    wreg(3'd5, 32'hFFF);
    @(negedge clk);
    cmp("R7", "busy trigger error", 32'(reg_rdata[2]), 32'h1);
    cmp("R11", "payload kept", 32'(pnl_db_out), 32'h56);
    cmp("R11", "channel kept", 32'(pnl_cs_n), 32'h2);
    wait_idle();
    @(negedge clk);
    cmp("R7", "error sticky", 32'(reg_rdata[2]), 32'h1);
    wreg(3'd4, 32'h4);
    @(negedge clk);
    cmp("R7", "error cleared", 32'(reg_rdata[2]), 32'h0);

    // R8: missing write flag, unprepared read
    wreg(3'd5, 32'h111);
    wreg(3'd0, 32'h0100_0012);
    wreg(3'd2, 32'h1);
    @(negedge clk);
    cmp("R8", "no write flag", 32'({pnl_cs_n, reg_rdata[2]}), 32'h7);
    wreg(3'd4, 32'h4);
    wreg(3'd3, 32'h1);
    @(negedge clk);
    cmp("R8", "unprepared read", 32'({pnl_cs_n, reg_rdata[2]}), 32'h7);
    wreg(3'd4, 32'h4);

    // R9: unusable code rejected, 9-bit masking
    wreg(3'd6, 32'hB6);
    wreg(3'd0, 32'h1100_0012);
    wreg(3'd2, 32'h1);
    @(negedge clk);
    cmp("R9", "bad code", 32'({pnl_cs_n, reg_rdata[2]}), 32'h7);
    wreg(3'd4, 32'h4);
    wreg(3'd6, 32'hB4);
    wreg(3'd0, 32'h11FF_FFFF);
    wreg(3'd2, 32'h1);
    @(negedge clk);
    cmp("R9", "9-bit payload", 32'(pnl_db_out), 32'h1FF);
    wait_idle();

    // R10: prepared read, 24-bit, frozen bus
    wreg(3'd6, 32'hBB);
    wreg(3'd1, 32'h0100_0000);
    freeze = 1'b1;
    pnl_db_in = 24'hABCDEF;
    wreg(3'd3, 32'h1);
    wait_idle();
    reg_raddr = 3'd1;
    @(negedge clk);
    cmp("R10", "read word", reg_rdata, 32'h0000_CDEF);
    freeze = 1'b0;

    // R10: 8-bit read on channel 1 with a long strobe and a moving bus
    wreg(3'd6, 32'h0B);
    wreg(3'd5, 32'h151);
    wreg(3'd1, 32'h0100_0000);
    wreg(3'd3, 32'h3);
    wait_idle();
    @(negedge clk);
    cmp("R10", "8-bit read high bits", 32'(reg_rdata[15:8]), 32'h0);

    // R12: trigger without go bit
    reg_raddr = 3'd4;
    wreg(3'd2, 32'h2);
    tick();
    @(negedge clk);
    cmp("R12", "no start", 32'({pnl_cs_n, reg_rdata[2:1]}), 32'hC);

    repeat (3) tick();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule